// File: doc/BRIEF.md
# Link Interface Restore Sequencer

This block sits on the PHY side of a parallel PHY-to-link-layer interface and brings that interface back into service after it has been reset or disabled. It watches the link power status level. While the level is low it times how long the interface has been idle. Once that time reaches a minimum restore interval, a rising power status starts the restore. The same restore runs whether the interface clock was stopped or the interface was only reset.

The restore has four phases. First comes a wake delay whose length depends on whether the PHY was in a low-power state. The interface clock enable then goes high and the PHY drives the control and data lines low for seven cycles. It then signals receive with an all-ones data-on marker on the data lines. Finally it settles on idle with zero data. From then on the interface is ready and link requests are accepted. If power status drops at any point, the sequencer goes back to its reset state and the restore timer starts again from zero.

Top module: `linkRestoreSeq`

## Requirements
- R1: During and right after reset, clkEn, dataOe, ready and reqAccept are 0, ctlOut is 2'b00 and dataOut is 8'h00.
- R2: The sequencer accepts a high pwrLvl only after pwrLvl has been sampled low on at least RESTORE_CYC consecutive edges in the reset state. A high pwrLvl seen earlier is ignored, the outputs stay at their R1 values, and the idle count restarts from zero.
- R3: Call the edge that accepts reassertion the start edge. clkEn goes high W+1 edges after it. W is WAKE_SLOW_CYC if lowPower was 1 at the start edge and WAKE_FAST_CYC otherwise. Until then all outputs keep their R1 values.
- R4: For the first LOW_CYC (7) cycles in which clkEn is high, dataOe is 1, ctlOut is 2'b00 and dataOut is 8'h00.
- R5: For the next RX_CYC cycles (at least 1), dataOe is 1, ctlOut carries the receive code 2'b10 and dataOut is 8'hFF.
- R6: After that, ctlOut is idle (2'b00), dataOut is 8'h00, dataOe and clkEn are 1 and ready is 1. These values hold while pwrLvl stays high. Control codes: 00 idle, 01 status, 10 receive, 11 grant.
- R7: reqAccept is 1 in the cycle after an edge that samples linkReq high while the interface is ready. A linkReq seen at any earlier point of the restore is dropped, and reqAccept stays 0.
- R8: If pwrLvl is sampled low in any phase after the start edge, the sequencer is back in its reset state after that edge. The outputs take their R1 values one edge later, and the idle count of R2 restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrLvl | input | 1 | Link power status level |
| lowPower | input | 1 | PHY was in a low-power state; selects the long wake delay |
| linkReq | input | 1 | Link request line |
| clkEn | output | 1 | Interface clock enable |
| ctlOut | output | 2 | Control bus code |
| dataOut | output | 8 | Data bus |
| dataOe | output | 1 | Output enable for control and data lines |
| ready | output | 1 | Restore complete, interface in service |
| reqAccept | output | 1 | Link request accepted this cycle |

## Verification
The assertions assume that pwrLvl, lowPower and linkReq are synchronous to clk and settle well before each rising edge. They also assume the parameters keep WAKE_FAST_CYC, WAKE_SLOW_CYC and RX_CYC at 1 or more. The stimulus changes every input only on the falling edge. It holds linkReq high through every phase, so that early requests are offered but not taken. It drops pwrLvl at chosen points in the wake, drive-low and receive phases, and it raises pwrLvl exactly at and one cycle short of the restore interval.

// File: rtl/linkRestorePkg.sv
package linkRestorePkg;

  typedef enum logic [1:0] {
    CTL_IDLE   = 2'b00,
    CTL_STATUS = 2'b01,
    CTL_RX     = 2'b10,
    CTL_GRANT  = 2'b11
  } ctlCodeT;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAKE,
    ST_LOW,
    ST_RX,
    ST_READY
  } seqStateT;

  typedef struct packed {
    logic    clkRun;
    logic    busDrive;
    ctlCodeT ctlCode;
    logic    dataOnes;
    logic    linkUp;
  } seqStrobeT;

endpackage

// File: rtl/linkRestoreCtrl.sv
module linkRestoreCtrl
  import linkRestorePkg::*;
#(
  parameter int RESTORE_CYC   = 16,
  parameter int WAKE_FAST_CYC = 3,
  parameter int WAKE_SLOW_CYC = 40,
  parameter int LOW_CYC       = 7,
  parameter int RX_CYC        = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pwrLvl,
  input  logic      lowPower,
  output seqStrobeT strobe
);

  localparam int RW = $clog2(RESTORE_CYC + 1);
  localparam int PH_MAX1 = (WAKE_SLOW_CYC > WAKE_FAST_CYC) ? WAKE_SLOW_CYC : WAKE_FAST_CYC;
  localparam int PH_MAX2 = (LOW_CYC > RX_CYC) ? LOW_CYC : RX_CYC;
  localparam int PH_MAX  = (PH_MAX1 > PH_MAX2) ? PH_MAX1 : PH_MAX2;
  localparam int PW = $clog2(PH_MAX + 1);
  localparam logic [RW-1:0] RESTORE_TOP = RW'(RESTORE_CYC);
  localparam logic [PW-1:0] WAKE_FAST_LD = PW'(WAKE_FAST_CYC - 1);
  localparam logic [PW-1:0] WAKE_SLOW_LD = PW'(WAKE_SLOW_CYC - 1);
  localparam logic [PW-1:0] LOW_LD = PW'(LOW_CYC - 1);
  localparam logic [PW-1:0] RX_LD  = PW'(RX_CYC - 1);

  seqStateT        state;
  logic [RW-1:0]   restoreCnt;
  logic [PW-1:0]   phaseCnt;
  logic            restoreDone;
  logic            phaseLast;

  assign restoreDone = (restoreCnt == RESTORE_TOP);
  assign phaseLast   = (phaseCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_OFF;
      restoreCnt <= '0;
      phaseCnt   <= '0;
    end else if (state != ST_OFF && !pwrLvl) begin
      state      <= ST_OFF;
      restoreCnt <= '0;
      phaseCnt   <= '0;
    end else begin
      case (state)
        ST_OFF: begin
          if (!pwrLvl) begin
            if (!restoreDone) restoreCnt <= restoreCnt + 1'b1;
          end else begin
            restoreCnt <= '0;
            if (restoreDone) begin
              state    <= ST_WAKE;
              phaseCnt <= lowPower ? WAKE_SLOW_LD : WAKE_FAST_LD;
            end
          end
        end
        ST_WAKE: begin
          if (phaseLast) begin
            state    <= ST_LOW;
            phaseCnt <= LOW_LD;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_LOW: begin
          if (phaseLast) begin
            state    <= ST_RX;
            phaseCnt <= RX_LD;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_RX: begin
          if (phaseLast) state <= ST_READY;
          else phaseCnt <= phaseCnt - 1'b1;
        end
        ST_READY: state <= ST_READY;
        default: state <= ST_OFF;
      endcase
    end
  end

  always_comb begin
    strobe = '{clkRun: 1'b0, busDrive: 1'b0, ctlCode: CTL_IDLE,
               dataOnes: 1'b0, linkUp: 1'b0};
    case (state)
      ST_LOW: begin
        strobe.clkRun   = 1'b1;
        strobe.busDrive = 1'b1;
      end
      ST_RX: begin
        strobe.clkRun   = 1'b1;
        strobe.busDrive = 1'b1;
        strobe.ctlCode  = CTL_RX;
        strobe.dataOnes = 1'b1;
      end
      ST_READY: begin
        strobe.clkRun   = 1'b1;
        strobe.busDrive = 1'b1;
        strobe.linkUp   = 1'b1;
      end
      default: ;
    endcase
  end

  // R8
  pwr_loss_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_OFF && !pwrLvl) |=> (state == ST_OFF && restoreCnt == '0));

  // R2
  early_start_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && pwrLvl && !restoreDone) |=> (state == ST_OFF));

  // R5
  low_to_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOW && phaseLast && pwrLvl) |=> (state == ST_RX));

  // R6
  ready_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_READY) |-> ($past(state) == ST_RX));

endmodule

// File: rtl/linkRestoreDp.sv
module linkRestoreDp
  import linkRestorePkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strobe,
  input  logic              linkReq,
  output logic              clkEn,
  output logic [1:0]        ctlOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              ready,
  output logic              reqAccept
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkEn     <= 1'b0;
      ctlOut    <= CTL_IDLE;
      dataOut   <= '0;
      dataOe    <= 1'b0;
      ready     <= 1'b0;
      reqAccept <= 1'b0;
    end else begin
      clkEn     <= strobe.clkRun;
      ctlOut    <= strobe.ctlCode;
      dataOut   <= strobe.dataOnes ? '1 : '0;
      dataOe    <= strobe.busDrive;
      ready     <= strobe.linkUp;
      reqAccept <= strobe.linkUp & linkReq;
    end
  end

  // R5
  rx_marker_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && dataOut != '0) |-> (ctlOut == CTL_RX && dataOut == '1));

  // R4
  drive_needs_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> clkEn);

endmodule

// File: rtl/linkRestoreSeq.sv
module linkRestoreSeq
  import linkRestorePkg::*;
#(
  parameter int RESTORE_CYC   = 16,
  parameter int WAKE_FAST_CYC = 3,
  parameter int WAKE_SLOW_CYC = 40,
  parameter int LOW_CYC       = 7,
  parameter int RX_CYC        = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrLvl,
  input  logic       lowPower,
  input  logic       linkReq,
  output logic       clkEn,
  output logic [1:0] ctlOut,
  output logic [7:0] dataOut,
  output logic       dataOe,
  output logic       ready,
  output logic       reqAccept
);

  seqStrobeT strobe;

  linkRestoreCtrl #(
    .RESTORE_CYC  (RESTORE_CYC),
    .WAKE_FAST_CYC(WAKE_FAST_CYC),
    .WAKE_SLOW_CYC(WAKE_SLOW_CYC),
    .LOW_CYC      (LOW_CYC),
    .RX_CYC       (RX_CYC)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .pwrLvl  (pwrLvl),
    .lowPower(lowPower),
    .strobe  (strobe)
  );

  linkRestoreDp #(.DATA_W(8)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .linkReq  (linkReq),
    .clkEn    (clkEn),
    .ctlOut   (ctlOut),
    .dataOut  (dataOut),
    .dataOe   (dataOe),
    .ready    (ready),
    .reqAccept(reqAccept)
  );

endmodule

// File: tb/linkRestoreSeq_tb_top.sv
module linkRestoreSeq_tb_top;

  localparam int RESTORE = 16;
  localparam int WFAST   = 3;
  localparam int WSLOW   = 40;
  localparam int LOWC    = 7;
  localparam int RXC     = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrLvl = 1'b0;
  logic lowPower = 1'b0;
  logic linkReq = 1'b1;
  logic clkEn, dataOe, ready, reqAccept;
  logic [1:0] ctlOut;
  logic [7:0] dataOut;

  always #4 clk = ~clk;

  linkRestoreSeq dut_i (
    .clk(clk), .rstN(rstN), .pwrLvl(pwrLvl), .lowPower(lowPower),
    .linkReq(linkReq), .clkEn(clkEn), .ctlOut(ctlOut), .dataOut(dataOut),
    .dataOe(dataOe), .ready(ready), .reqAccept(reqAccept)
  );

  typedef struct {
    logic       clkEn;
    logic       oe;
    logic [1:0] ctl;
    logic [7:0] data;
    logic       rdy;
    logic       acc;
    string      tag;
  } expT;

  expT expQ[$];
  expT pend;
  int  checks = 0;
  int  fails = 0;
  bit  finished = 0;

  function automatic expT mk(logic ce, logic oe, logic [1:0] ctl, logic [7:0] d,
                             logic r, string tag);
    expT e;
    e.clkEn = ce; e.oe = oe; e.ctl = ctl; e.data = d; e.rdy = r; e.acc = 1'b0;
    e.tag = tag;
    return e;
  endfunction

  function automatic expT offExp(string tag);  return mk(0, 0, 2'b00, 8'h00, 0, tag); endfunction
  function automatic expT wakeExp();  return mk(0, 0, 2'b00, 8'h00, 0, "R3"); endfunction
  function automatic expT lowExp();   return mk(1, 1, 2'b00, 8'h00, 0, "R4"); endfunction
  function automatic expT rxExp();    return mk(1, 1, 2'b10, 8'hFF, 0, "R5"); endfunction
  function automatic expT readyExp(); return mk(1, 1, 2'b00, 8'h00, 1, "R6 R7"); endfunction

  // Drive one cycle: inputs set on the falling edge, and the item expected
  // after the next rising edge reflects the state held before that edge.
  task automatic step(logic pwr, logic req, expT nextExp);
    expT e;
    @(negedge clk);
    pwrLvl  = pwr;
    linkReq = req;
    e = pend;
    e.acc = pend.rdy & req;
    expQ.push_back(e);
    pend = nextExp;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 1, offExp(tag));
  endtask

  // R3 R4 R5 R6: walk a full restore; abortAt >= 0 drops power at that edge (R8)
  task automatic restore(logic lp, int abortAt);
    int w;
    w = lp ? WSLOW : WFAST;
    lowPower = lp;
    for (int j = 0; j < w + LOWC + RXC + 4; j++) begin
      if (j == abortAt) begin
        step(0, 1, offExp("R8"));
        return;
      end
      if (j < w)                step(1, 1, wakeExp());
      else if (j < w + LOWC)    step(1, 1, lowExp());
      else if (j < w + LOWC + RXC) step(1, 1, rxExp());
      else                      step(1, 1, readyExp());
    end
  endtask

  // Scoreboard monitor: samples 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expT e;
      e = expQ.pop_front();
      checks++;
      if (clkEn !== e.clkEn || dataOe !== e.oe || ctlOut !== e.ctl ||
          dataOut !== e.data || ready !== e.rdy || reqAccept !== e.acc) begin
        fails++;
        $display("FAIL %s: got clkEn=%b oe=%b ctl=%b data=%h ready=%b acc=%b, expected clkEn=%b oe=%b ctl=%b data=%h ready=%b acc=%b",
                 e.tag, clkEn, dataOe, ctlOut, dataOut, ready, reqAccept,
                 e.clkEn, e.oe, e.ctl, e.data, e.rdy, e.acc);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    pend = offExp("R1");
    repeat (3) @(posedge clk);
    // R1: outputs while reset is held
    @(negedge clk);
    checks++;
    if (clkEn !== 0 || dataOe !== 0 || ctlOut !== 2'b00 || dataOut !== 8'h00 ||
        ready !== 0 || reqAccept !== 0) begin
      fails++;
      $display("FAIL R1: got clkEn=%b oe=%b ctl=%b data=%h ready=%b acc=%b, expected all zero",
               clkEn, dataOe, ctlOut, dataOut, ready, reqAccept);
    end
    rstN = 1'b1;

    // R2: exactly the minimum idle time from reset, then fast restore
    idle(RESTORE, "R1");
    restore(0, -1);
    // R7: request toggling while ready
    step(1, 0, readyExp());
    step(1, 1, readyExp());
    step(1, 0, readyExp());
    step(1, 1, readyExp());

    // R8 then R2: drop from ready, idle the minimum, slow restore (R3)
    idle(RESTORE + 1, "R2");
    restore(1, -1);

    // R2: reassert one cycle short of the minimum: ignored and count restarts
    idle(RESTORE, "R2");
    for (int i = 0; i < 4; i++) step(1, 1, offExp("R2"));
    idle(RESTORE - 1, "R2");
    for (int i = 0; i < 3; i++) step(1, 1, offExp("R2"));

    // R8: abort during drive-low
    idle(RESTORE, "R8");
    restore(0, WFAST + 3);
    // R8: abort during slow wake
    idle(RESTORE, "R8");
    restore(1, 5);
    // R8: abort during receive indication
    idle(RESTORE, "R8");
    restore(0, WFAST + LOWC + 1);

    // Final fast restore after abort with minimum idle
    idle(RESTORE, "R8");
    restore(0, -1);
    step(1, 0, readyExp());

    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule